// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block turns a raw, possibly bouncing link-status indication from a physical-layer interface into a clean qualified link-up flag. The link counts as up only after the raw indication has stayed high without a break for a stability window. The window is chosen by a 3-bit code from a fixed non-linear table, which runs from zero time to two seconds. The window is timed by counting pulses of a free-running 1 µs reference tick. Each change of the qualified flag is also reported as a single-cycle event.

The selection code sits in a register that is loaded by `selLoad`. After reset it holds code 2. The parameter `TIME_DIV` divides every table entry, so one tick can stand for `TIME_DIV` microseconds. The default is 1, which gives exact 1 µs timing.

Top module: `link_stability_qual`

## Requirements
- R1: After reset, `linkUp` and `linkChg` are 0 and the active selection code is 2.
- R2: The selection codes 0 to 7 map to windows of 0, 500, 1000, 64000, 256000, 512000, 1000000 and 2000000 µs. Each window in ticks is that value divided by `TIME_DIV`.
- R3: With a non-zero window of N ticks, `linkUp` rises on the clock edge that samples the N-th tick seen while `rawLink` is high without a break since the count began.
- R4: With code 0, `linkUp` rises on the first clock edge that samples `rawLink` high.
- R5: A clock edge that samples `rawLink` low before qualification completes discards all ticks counted so far.
- R6: While `linkUp` is 1, the first clock edge that samples `rawLink` low clears `linkUp`.
- R7: A load (`selLoad`=1) with a code different from the active one takes effect at that edge and restarts the count under the new window. A tick in that cycle is not counted. A load with the same code changes nothing.
- R8: `linkChg` is 1 for exactly the cycle after each edge at which `linkUp` changes, and 0 at all other times.
- R9: A code change while `linkUp` is 1 does not affect `linkUp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawLink | input | 1 | Unqualified link status, high means link present |
| usTick | input | 1 | One-cycle reference tick, one per 1 µs (times TIME_DIV) |
| selLoad | input | 1 | Strobe that loads `selCode` into the selection register |
| selCode | input | 3 | Stability window selection code |
| linkUp | output | 1 | Qualified link-up flag |
| linkChg | output | 1 | One-cycle pulse on each change of `linkUp` |

## Verification
The hardest cases to reach are the long windows (codes 4 to 7), where up to two million ticks must pass without a break. Another hard case is the exact edge where the final tick lands in the same cycle as a drop of the raw line or a code reload. The bench builds the qualifier with a time divisor of 50, so every code can be run to completion. It then mixes random raw-line drops, sparse ticks and reloads of the short codes. This repeatedly lands those events on or next to the completing tick.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam logic [2:0] SEL_DEFAULT = 3'd2;

  typedef enum logic [1:0] {
    LS_DOWN = 2'd0,
    LS_QUAL = 2'd1,
    LS_UP   = 2'd2
  } linkState_t;

  // Strobes from control to the tick counter.
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntCtl_t;

  // Window length in microseconds for each selection code.
  function automatic int unsigned windowUs(input logic [2:0] code);
    case (code)
      3'd0:    windowUs = 0;
      3'd1:    windowUs = 500;
      3'd2:    windowUs = 1000;
      3'd3:    windowUs = 64000;
      3'd4:    windowUs = 256000;
      3'd5:    windowUs = 512000;
      3'd6:    windowUs = 1000000;
      default: windowUs = 2000000;
    endcase
  endfunction

endpackage

// File: rtl/lsq_datapath.sv
module lsq_datapath
  import lsq_pkg::*;
#(
  parameter int unsigned TIME_DIV = 1,
  parameter int unsigned CNT_W    = 21
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selLoad,
  input  logic [2:0] selCode,
  input  cntCtl_t    cntCtl,
  output logic       selChange,
  output logic       targetZero,
  output logic       lastTick
);

  localparam int NUM_CODES = 8;

  logic [CNT_W-1:0] targetTbl [NUM_CODES];
  logic [2:0]       selReg;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] target;

  // Window constants per code, scaled by the tick divisor.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
    assign targetTbl[g] = CNT_W'(windowUs(3'(g)) / TIME_DIV);
  end

  assign target     = targetTbl[selReg];
  assign targetZero = (target == '0);
  assign lastTick   = (tickCnt == target - CNT_W'(1));
  assign selChange  = selLoad && (selCode != selReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= SEL_DEFAULT;
    end else if (selLoad) begin
      selReg <= selCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (cntCtl.clrCnt) begin
      tickCnt <= '0;
    end else if (cntCtl.incCnt) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= target) else $error("tick count beyond window"); // R3

  AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> (tickCnt == '0)) else $error("count kept over reload"); // R7

  AST_SAME_CODE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (selLoad && !selChange) |=> $stable(selReg)) else $error("same-code load altered code"); // R7

endmodule

// File: rtl/lsq_control.sv
module lsq_control
  import lsq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rawLink,
  input  logic    usTick,
  input  logic    selChange,
  input  logic    targetZero,
  input  logic    lastTick,
  output cntCtl_t cntCtl,
  output logic    linkUp,
  output logic    linkChg
);

  linkState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    cntCtl.clrCnt = 1'b0;
    cntCtl.incCnt = 1'b0;
    if (state == LS_UP) begin
      if (!rawLink) begin
        cntCtl.clrCnt = 1'b1;
        stateNext     = LS_DOWN;
      end
    end else begin
      if (!rawLink) begin
        cntCtl.clrCnt = 1'b1;
        stateNext     = LS_DOWN;
      end else if (selChange) begin
        cntCtl.clrCnt = 1'b1;
        stateNext     = LS_QUAL;
      end else if (targetZero) begin
        cntCtl.clrCnt = 1'b1;
        stateNext     = LS_UP;
      end else if (usTick && lastTick) begin
        cntCtl.clrCnt = 1'b1;
        stateNext     = LS_UP;
      end else begin
        cntCtl.incCnt = usTick;
        stateNext     = LS_QUAL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= LS_DOWN;
      linkChg <= 1'b0;
    end else begin
      state   <= stateNext;
      linkChg <= (stateNext == LS_UP) != (state == LS_UP);
    end
  end

  assign linkUp = (state == LS_UP);

  AST_DROP_ON_RAW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !rawLink |=> !linkUp) else $error("link held while raw low"); // R6

  AST_RISE_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (!linkUp && !rawLink) |=> !linkUp) else $error("rise without raw"); // R3

  AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp != $past(linkUp)) |-> linkChg) else $error("missing change pulse"); // R8

  AST_CHG_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    linkChg |-> (linkUp != $past(linkUp))) else $error("spurious change pulse"); // R8

  AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && rawLink) |=> linkUp) else $error("link dropped with raw high"); // R9

endmodule

// File: rtl/link_stability_qual.sv
module link_stability_qual
  import lsq_pkg::*;
#(
  parameter int unsigned TIME_DIV = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawLink,
  input  logic       usTick,
  input  logic       selLoad,
  input  logic [2:0] selCode,
  output logic       linkUp,
  output logic       linkChg
);

  localparam int unsigned MAX_TICKS = windowUs(3'd7) / TIME_DIV;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  cntCtl_t cntCtl;
  logic    selChange;
  logic    targetZero;
  logic    lastTick;

  lsq_datapath #(
    .TIME_DIV (TIME_DIV),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .selLoad    (selLoad),
    .selCode    (selCode),
    .cntCtl     (cntCtl),
    .selChange  (selChange),
    .targetZero (targetZero),
    .lastTick   (lastTick)
  );

  lsq_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .rawLink    (rawLink),
    .usTick     (usTick),
    .selChange  (selChange),
    .targetZero (targetZero),
    .lastTick   (lastTick),
    .cntCtl     (cntCtl),
    .linkUp     (linkUp),
    .linkChg    (linkChg)
  );

endmodule

// File: tb/link_stability_qual_test.sv
`timescale 1ns/1ps
module link_stability_qual_test;

  localparam int unsigned DIV = 50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawLink = 1'b0;
  logic       usTick = 1'b0;
  logic       selLoad = 1'b0;
  logic [2:0] selCode = 3'd0;
  logic       linkUp;
  logic       linkChg;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  // Reference state.
  bit         mUp  = 1'b0;
  bit         mChg = 1'b0;
  int         mCnt = 0;
  logic [2:0] mSel = 3'd2;

  always #10 clk = ~clk;

  link_stability_qual #(.TIME_DIV(DIV)) uut (
    .clk     (clk),
    .rstN    (rstN),
    .rawLink (rawLink),
    .usTick  (usTick),
    .selLoad (selLoad),
    .selCode (selCode),
    .linkUp  (linkUp),
    .linkChg (linkChg)
  );

  // Window in ticks per code, from the R2 table.
  function automatic int winTicks(input logic [2:0] c);
    int us;
    case (c)
      3'd0: us = 0;       3'd1: us = 500;
      3'd2: us = 1000;    3'd3: us = 64000;
      3'd4: us = 256000;  3'd5: us = 512000;
      3'd6: us = 1000000; default: us = 2000000;
    endcase
    return us / DIV;
  endfunction

  // Expected state after one edge, from R3..R9.
  task automatic modelStep(input bit raw, input bit tk, input bit ld, input logic [2:0] c);
    mChg = 1'b0;
    if (!mUp) begin
      if (!raw) mCnt = 0;
      else if (ld && c != mSel) mCnt = 0;
      else if (winTicks(mSel) == 0) begin mUp = 1'b1; mChg = 1'b1; mCnt = 0; end
      else if (tk) begin
        mCnt++;
        if (mCnt == winTicks(mSel)) begin mUp = 1'b1; mChg = 1'b1; mCnt = 0; end
      end
    end else if (!raw) begin
      mUp = 1'b0; mChg = 1'b1; mCnt = 0;
    end
    if (ld) mSel = c;
  endtask

  task automatic check(input string tag);
    nChecks++;
    if (linkUp !== mUp || linkChg !== mChg) begin
      nFails++;
      $display("FAIL %s: up/chg actual %b/%b expected %b/%b at %0t",
               tag, linkUp, linkChg, mUp, mChg, $time);
    end
  endtask

  task automatic cyc(input bit raw, input bit tk, input bit ld, input logic [2:0] c,
                     input string tag);
    rawLink = raw; usTick = tk; selLoad = ld; selCode = c;
    modelStep(raw, tk, ld, c);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  // Run one code to completion with a tick every cycle.
  task automatic fullWindow(input logic [2:0] c, input string tag);
    int n;
    cyc(1'b0, 1'b0, 1'b1, c, "R7");
    n = winTicks(c);
    for (int i = 0; i < n + 2; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, tag);
    cyc(1'b0, 1'b0, 1'b0, 3'd0, "R6");
    cyc(1'b0, 1'b0, 1'b0, 3'd0, "R8");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // R1 default code 2: 20 ticks here.
    for (int i = 0; i < 25; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R1 default code");
    cyc(1'b0, 1'b0, 1'b0, 3'd0, "R6");

    // R4 code 0 passes raw straight through.
    cyc(1'b0, 1'b0, 1'b1, 3'd0, "R7");
    cyc(1'b1, 1'b0, 1'b0, 3'd0, "R4");
    cyc(1'b1, 1'b0, 1'b0, 3'd0, "R8");
    cyc(1'b0, 1'b0, 1'b0, 3'd0, "R6");

    // R2/R3 every non-zero code to completion.
    for (int k = 1; k < 8; k++) fullWindow(3'(k), "R2 R3 window");

    // R5 drop one tick before completion, code 1 (10 ticks).
    cyc(1'b0, 1'b0, 1'b1, 3'd1, "R7");
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R5");
    cyc(1'b0, 1'b1, 1'b0, 3'd0, "R5");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R5 restart");

    // R9 code change while up; R7 same-code reload does nothing.
    cyc(1'b1, 1'b1, 1'b1, 3'd3, "R9");
    cyc(1'b1, 1'b1, 1'b0, 3'd0, "R9");
    cyc(1'b0, 1'b0, 1'b1, 3'd1, "R6");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R7");
    cyc(1'b1, 1'b1, 1'b1, 3'd1, "R7 same code");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R7 same code");
    cyc(1'b0, 1'b0, 1'b0, 3'd0, "R6");
    // R7 change mid-count restarts under new window (code 2, 20 ticks).
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R7");
    cyc(1'b1, 1'b1, 1'b1, 3'd2, "R7 change");
    for (int i = 0; i < 22; i++) cyc(1'b1, 1'b1, 1'b0, 3'd0, "R7 change");

    // Random mix over short codes.
    for (int i = 0; i < 6000; i++) begin
      bit raw, tk, ld;
      logic [2:0] c;
      raw = ($urandom_range(0, 39) != 0);
      tk  = ($urandom_range(0, 2) != 0);
      ld  = ($urandom_range(0, 59) == 0);
      c   = 3'($urandom_range(0, 2));
      cyc(raw, tk, ld, c, "R3 R5 R8 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule